// File: doc/BRIEF.md
# System Clock Ratio Detector and 256-fs Enable Divider

This block works out how fast the system clock runs relative to the audio sampling rate and turns that into a processing enable that always pulses at 256 times the sampling rate. In slave operation it counts system-clock cycles between consecutive rising edges of the incoming word clock. It sorts that count into one of four ratios: 256, 384, 512 or 768 cycles per sample. Once two periods in a row give the same answer, it reports the ratio as locked and starts the enable divider. A count that fits no ratio, or a word clock that stops, raises an error and keeps the enable low.

In master operation a two-bit mode input sets the ratio directly. Word-clock detection is bypassed, and the 768 ratio cannot be chosen. A power-down input clears every internal state and holds all outputs at zero. The word clock is assumed to come from the same source as the system clock, so only a two-flop synchronizer sits on its path.

The lock tracker is a four-state machine. SEEK waits for the first measured period. CAND holds a candidate ratio seen once. LOCK holds a ratio seen on two consecutive periods. FAULT is entered on an unusable period. The transitions are:
- SEEK to CAND on a good period, and SEEK to FAULT on a bad one.
- CAND to LOCK when the same ratio repeats. CAND stays in CAND, with a new candidate, when a different ratio arrives.
- LOCK to CAND when a different ratio arrives.
- CAND or LOCK to FAULT on a bad period.
- FAULT to CAND on a good period.
- Any state to FAULT when the word clock stalls.
- Any state to SEEK while powered down or in master mode.

Top module: `sysclk_ratio_detect`

## Requirements
- R1: In slave mode (`mode` = 00) with a steady word-clock period of 256, 384, 512 or 768 system clocks, `ratio` settles to 0, 1, 2 or 3 respectively, with `locked` = 1 and `err` = 0.
- R2: A measured period within ±4 cycles of a supported ratio is accepted as that ratio. A period 5 cycles away from every supported ratio is rejected.
- R3: `locked` rises only after two consecutive measured periods give the same ratio. After the first good period it is still 0.
- R4: A measured period that gives a different supported ratio clears `locked` at once. A period that repeats the locked ratio keeps it set.
- R5: A period matching no supported ratio sets `err` and holds `locked` and `en256` low.
- R6: If no word-clock rising edge arrives within 2047 system clocks of the previous one, `err` is set and `locked` is cleared.
- R7: While a ratio is active, `en256` pulses as follows. At 256 it pulses every cycle. At 384 it gives 2 pulses every 3 cycles, with spacings alternating 1 and 2. At 512 it pulses every 2nd cycle. At 768 it pulses every 3rd cycle.
- R8: Master mode applies when `mode` is not 00. Mode 11 selects ratio 0 (256), 10 selects 1 (384) and 01 selects 2 (512). `locked` = 1 and `err` = 0, and the word clock is ignored.
- R9: One cycle after `power_down` is sampled high, `ratio`, `locked`, `err` and `en256` are all 0. Detection restarts from SEEK when `power_down` is released.
- R10: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| power_down | input | 1 | High: clear state, outputs held at zero |
| mode | input | 2 | 00 slave detection; 11/10/01 master at 256/384/512 |
| wclk | input | 1 | Word clock at the sampling rate |
| ratio | output | 2 | Ratio code: 0=256, 1=384, 2=512, 3=768 |
| locked | output | 1 | Ratio confirmed (always 1 in master mode) |
| err | output | 1 | Unsupported or stalled word-clock period |
| en256 | output | 1 | Enable pulse at 256 times the sampling rate |

## Verification
A word-clock rising edge passes through the synchronizer, the edge detector and the period register, then the lock machine and the output register. The status outputs therefore change about five system clocks after the edge that closes a period. The bench counts the rising edges it generates and samples 8 cycles after the edge of interest, which is well before the next period can close. Sweeps, stall tests and power-down tests use waits of several periods plus a fixed margin, so lock has settled before sampling. Mode and power-down changes reach the registered outputs one cycle later, and the enable rate is checked by counting pulses and gaps over windows that are a multiple of every divide pattern.

// File: rtl/srd_pkg.sv
package srd_pkg;

    typedef enum logic [1:0] {
        RC_256 = 2'd0,
        RC_384 = 2'd1,
        RC_512 = 2'd2,
        RC_768 = 2'd3
    } ratio_e;

    typedef struct packed {
        logic   ok;
        ratio_e code;
    } class_t;

    localparam int BASE_DIV = 256;

    // system clocks per sample for each ratio code
    function automatic int ratio_cycles(ratio_e r);
        int n;
        unique case (r)
            RC_256: n = BASE_DIV;
            RC_384: n = BASE_DIV + BASE_DIV / 2;
            RC_512: n = 2 * BASE_DIV;
            RC_768: n = 3 * BASE_DIV;
        endcase
        return n;
    endfunction

    // length of the enable pattern for each ratio
    function automatic int pattern_len(ratio_e r);
        int n;
        unique case (r)
            RC_256: n = 1;
            RC_384: n = 3;
            RC_512: n = 2;
            RC_768: n = 3;
        endcase
        return n;
    endfunction

    function automatic class_t classify(int n, int tol);
        class_t res;
        res.ok   = 1'b0;
        res.code = RC_256;
        for (int i = 0; i < 4; i++) begin
            if (n >= ratio_cycles(ratio_e'(i[1:0])) - tol &&
                n <= ratio_cycles(ratio_e'(i[1:0])) + tol) begin
                res.ok   = 1'b1;
                res.code = ratio_e'(i[1:0]);
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/srd_wclk_sync.sv
module srd_wclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic wclk_in,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= wclk_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;

endmodule

// File: rtl/srd_period_meter.sv
module srd_period_meter
    import srd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   rise,
    output logic   ev,
    output logic   ev_ok,
    output ratio_e ev_code,
    output logic   stall
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;
    class_t           cls_c;

    always_comb cls_c = classify(int'(cnt_q), TOL);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            ev      <= 1'b0;
            ev_ok   <= 1'b0;
            ev_code <= RC_256;
            stall   <= 1'b0;
        end else begin
            ev    <= 1'b0;
            stall <= 1'b0;
            if (rise) begin
                if (armed_q) begin
                    ev      <= 1'b1;
                    ev_ok   <= cls_c.ok;
                    ev_code <= cls_c.code;
                end
                cnt_q   <= CNT_ONE;
                armed_q <= 1'b1;
            end else if (armed_q) begin
                if (cnt_q == CNT_MAX) begin
                    stall   <= 1'b1;
                    armed_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + CNT_ONE;
                end
            end
        end
    end

endmodule

// File: rtl/srd_lock_fsm.sv
module srd_lock_fsm
    import srd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   ev,
    input  logic   ev_ok,
    input  ratio_e ev_code,
    input  logic   stall,
    output logic   is_locked,
    output logic   is_fault,
    output ratio_e code
);
    typedef enum logic [1:0] {ST_SEEK, ST_CAND, ST_LOCK, ST_FAULT} state_e;

    state_e state_q, state_d;
    ratio_e cand_q, cand_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            state_q <= ST_SEEK;
            cand_q  <= RC_256;
        end else begin
            state_q <= state_d;
            cand_q  <= cand_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cand_d  = cand_q;
        if (ev && ev_ok) cand_d = ev_code;
        if (stall) begin
            state_d = ST_FAULT;
        end else if (ev) begin
            unique case (state_q)
                ST_SEEK:  state_d = ev_ok ? ST_CAND : ST_FAULT;
                ST_CAND:  state_d = !ev_ok ? ST_FAULT :
                                    (ev_code == cand_q) ? ST_LOCK : ST_CAND;
                ST_LOCK:  state_d = !ev_ok ? ST_FAULT :
                                    (ev_code == cand_q) ? ST_LOCK : ST_CAND;
                ST_FAULT: state_d = ev_ok ? ST_CAND : ST_FAULT;
            endcase
        end
    end

    // outputs
    always_comb begin
        is_locked = 1'b0;
        is_fault  = 1'b0;
        code      = RC_256;
        unique case (state_q)
            ST_SEEK:  ;
            ST_CAND:  code = cand_q;
            ST_LOCK: begin
                is_locked = 1'b1;
                code      = cand_q;
            end
            ST_FAULT: is_fault = 1'b1;
        endcase
    end

endmodule

// File: rtl/srd_en_div.sv
module srd_en_div
    import srd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  ratio_e ratio,
    output logic   en
);
    logic [1:0] ph_q;
    int         len_c;

    always_comb len_c = pattern_len(ratio);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q <= 2'd0;
            en   <= 1'b0;
        end else begin
            en   <= (ratio == RC_256) || (ph_q == 2'd0) ||
                    (ratio == RC_384 && ph_q == 2'd1);
            ph_q <= (int'(ph_q) >= len_c - 1) ? 2'd0 : ph_q + 2'd1;
        end
    end

endmodule

// File: rtl/sysclk_ratio_detect.sv
module sysclk_ratio_detect
    import srd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       power_down,
    input  logic [1:0] mode,
    input  logic       wclk,
    output logic [1:0] ratio,
    output logic       locked,
    output logic       err,
    output logic       en256
);
    logic   master_c, clear_c, run_c;
    ratio_e mratio_c, ratio_c;
    logic   rise;
    logic   ev, ev_ok, stall;
    ratio_e ev_code, fsm_code;
    logic   fsm_locked, fsm_fault;

    assign master_c = (mode != 2'b00);
    assign clear_c  = power_down | master_c;

    always_comb begin
        unique case (mode)
            2'b11:   mratio_c = RC_256;
            2'b10:   mratio_c = RC_384;
            2'b01:   mratio_c = RC_512;
            default: mratio_c = RC_256;
        endcase
    end

    assign ratio_c = master_c ? mratio_c : fsm_code;
    assign run_c   = !power_down && (master_c || fsm_locked);

    srd_wclk_sync u_sync (
        .clk(clk), .rst_n(rst_n), .clear(clear_c),
        .wclk_in(wclk), .rise(rise)
    );

    srd_period_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
        .clk(clk), .rst_n(rst_n), .clear(clear_c), .rise(rise),
        .ev(ev), .ev_ok(ev_ok), .ev_code(ev_code), .stall(stall)
    );

    srd_lock_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clear(clear_c),
        .ev(ev), .ev_ok(ev_ok), .ev_code(ev_code), .stall(stall),
        .is_locked(fsm_locked), .is_fault(fsm_fault), .code(fsm_code)
    );

    srd_en_div u_div (
        .clk(clk), .rst_n(rst_n), .run(run_c), .ratio(ratio_c), .en(en256)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || power_down) begin
            ratio  <= 2'd0;
            locked <= 1'b0;
            err    <= 1'b0;
        end else begin
            ratio  <= ratio_c;
            locked <= master_c | fsm_locked;
            err    <= !master_c & fsm_fault;
        end
    end

endmodule

// File: rtl/srd_chk.sv
module srd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       power_down,
    input logic [1:0] mode,
    input logic [1:0] ratio,
    input logic       locked,
    input logic       err,
    input logic       en256
);
    // R9
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (ratio == 2'd0 && !locked && !err && !en256));

    // R8
    master_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!power_down && mode == 2'b11) |=> (locked && !err && ratio == 2'd0));

    // R5
    err_no_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!en256 && !locked));

    // R7
    half_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en256 && locked && ratio == 2'd2) |=> (!en256 || ratio != 2'd2));

    // R7
    third_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en256 && locked && ratio == 2'd3) |=> (!en256 || ratio != 2'd3));

endmodule

bind sysclk_ratio_detect srd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .power_down(power_down), .mode(mode),
    .ratio(ratio), .locked(locked), .err(err), .en256(en256)
);

// File: tb/tb_sysclk_ratio_detect.sv
module tb_sysclk_ratio_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       power_down = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       wclk = 1'b0;
    logic [1:0] ratio;
    logic       locked, err, en256;

    int wper   = 0;
    int rise_n = 0;
    int n_vec  = 0;
    int n_bad  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sysclk_ratio_detect dut (
        .clk(clk), .rst_n(rst_n), .power_down(power_down), .mode(mode),
        .wclk(wclk), .ratio(ratio), .locked(locked), .err(err), .en256(en256)
    );

    // word-clock generator, period captured at each rising edge
    always begin
        int p;
        p = wper;
        if (p == 0) begin
            @(negedge clk);
        end else begin
            wclk = 1'b1;
            rise_n++;
            repeat (p / 2) @(negedge clk);
            wclk = 1'b0;
            repeat (p - p / 2) @(negedge clk);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_en(input int w, output int n, output int gmin, output int gmax);
        int last;
        last = -1; n = 0; gmin = 99999; gmax = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            if (en256) begin
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
                n++;
            end
        end
    endtask

    function automatic int base_of(int code);
        return (code == 0) ? 256 : (code == 1) ? 384 : (code == 2) ? 512 : 768;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        int n, gmin, gmax, r0;
        int offs[5] = '{-5, -4, 0, 4, 5};

        // R10: reset state
        repeat (4) @(negedge clk);
        chk("R10 ratio", ratio, 0);
        chk("R10 locked", locked, 0);
        chk("R10 err", err, 0);
        chk("R10 en256", en256, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: first good period does not lock, second does
        wper = 256;
        wait (rise_n == 2);
        repeat (8) @(negedge clk);
        chk("R3 locked after one period", locked, 0);
        chk("R3 err after one period", err, 0);
        wait (rise_n == 3);
        repeat (8) @(negedge clk);
        chk("R3 locked after two periods", locked, 1);
        chk("R1 ratio 256", ratio, 0);

        // R1 R2 R5 R7: sweep ratios and tolerance edges
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 5; k++) begin
                bit good;
                good = (offs[k] >= -4 && offs[k] <= 4);
                wper = base_of(c) + offs[k];
                repeat (3 * wper + 800) @(negedge clk);
                chk(good ? "R2 locked in tolerance" : "R2 rejected outside tolerance",
                    locked, good ? 1 : 0);
                chk("R5 err flag", err, good ? 0 : 1);
                if (good) chk("R1 ratio code", ratio, c);
                if (offs[k] == 0) begin
                    count_en(1536, n, gmin, gmax);
                    chk("R7 slave enable count", n, 1536 * 256 / base_of(c));
                    chk("R7 slave max gap", gmax, (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 2 : 3);
                    chk("R7 slave min gap", gmin, (c == 0) ? 1 : (c == 1) ? 1 : (c == 2) ? 2 : 3);
                end
                if (!good) begin
                    count_en(300, n, gmin, gmax);
                    chk("R5 enable held low", n, 0);
                end
            end
        end

        // R6: stalled word clock
        wper = 512;
        repeat (3 * 512 + 800) @(negedge clk);
        chk("R6 locked before stall", locked, 1);
        wper = 0;
        repeat (2047 + 800) @(negedge clk);
        chk("R6 err on stall", err, 1);
        chk("R6 locked on stall", locked, 0);

        // R4: mismatch drops lock, repeat keeps it
        wper = 512;
        repeat (4 * 512 + 800) @(negedge clk);
        chk("R4 locked at 512", locked, 1);
        r0 = rise_n;
        wait (rise_n == r0 + 1);
        wper = 384;
        wait (rise_n == r0 + 2);
        repeat (8) @(negedge clk);
        chk("R4 same ratio keeps lock", locked, 1);
        chk("R4 ratio still 512", ratio, 2);
        wait (rise_n == r0 + 3);
        repeat (8) @(negedge clk);
        chk("R4 mismatch drops lock", locked, 0);
        chk("R4 no err on mismatch", err, 0);
        wait (rise_n == r0 + 4);
        repeat (8) @(negedge clk);
        chk("R3 relock at 384", locked, 1);
        chk("R1 ratio 384", ratio, 1);

        // R8: master mode, word clock off-ratio and ignored
        wper = 300;
        for (int m = 1; m < 4; m++) begin
            int code;
            code = (m == 3) ? 0 : (m == 2) ? 1 : 2;
            mode = m[1:0];
            repeat (4) @(negedge clk);
            chk("R8 master locked", locked, 1);
            chk("R8 master err", err, 0);
            chk("R8 master ratio", ratio, code);
            count_en(1536, n, gmin, gmax);
            chk("R8 R7 master enable count", n, 1536 * 256 / base_of(code));
            chk("R7 master max gap", gmax, (code == 0) ? 1 : 2);
        end

        // R9: power-down
        mode = 2'b11;
        wper = 256;
        repeat (4) @(negedge clk);
        power_down = 1'b1;
        @(negedge clk);
        chk("R9 locked cleared", locked, 0);
        chk("R9 ratio cleared", ratio, 0);
        chk("R9 en256 cleared", en256, 0);
        count_en(200, n, gmin, gmax);
        chk("R9 no enable in power-down", n, 0);
        mode = 2'b00;
        wper = 768;
        repeat (1000) @(negedge clk);
        chk("R9 err stays low in power-down", err, 0);
        chk("R9 locked stays low in power-down", locked, 0);
        power_down = 1'b0;
        repeat (4 * 768 + 800) @(negedge clk);
        chk("R9 relock after release", locked, 1);
        chk("R1 ratio 768 after release", ratio, 3);

        finish_run();
    end

endmodule